// File: doc/BRIEF.md
# Transmit Phase-Compensation FIFO

This block moves 16-bit transmit words from the parallel input clock domain into the word clock domain of the transmit shifter. That word clock is the chosen serial bit clock divided by 16. The two clocks run at the same nominal rate, but their phase relation is unknown. The FIFO absorbs that phase offset. On every rising edge of its own clock, each side moves one word. No handshake exists at either edge of the block.

A dedicated active-low FIFO reset places the write pointer half a depth ahead of the read pointer, which gives the widest margin against either side catching the other. If the margin is ever used up, the block keeps running in a defined way. When full, it drops the incoming word. When empty, it repeats the last word it delivered. In both cases it raises a sticky error flag, which only the FIFO reset clears. The device-wide reset clears the output word only and leaves the pointers and the flag alone. The pointers cross between domains as Gray code through two-stage synchronisers. The FIFO reset is synchronised separately into each domain.

Top module: `tx_phase_fifo`

## Requirements
- R1: On each rising `wclk` edge where the write side is out of FIFO reset and does not see the FIFO as full, the word on `wdata` is stored. Stored words leave in the order they were written.
- R2: On each rising `rclk` edge where the read side is out of FIFO reset and does not see the FIFO as empty, the next stored word is loaded into `dout`. With equal clock rates and no faults, `dout` shows a gap-free, in-order copy of the written sequence.
- R3: When the write side sees eight stored words (full), the word presented on that edge is discarded, the stored words are kept, and `fifo_err` goes to 1.
- R4: When the read side sees the FIFO empty, `dout` keeps its previous value (the last word delivered) and `fifo_err` goes to 1.
- R5: `fifo_err` is the OR of a write-side flag and a read-side flag. Each flag stays at 1 until the FIFO reset reaches its domain, which sets it to 0.
- R6: `fifo_rst_n` low is seen in each domain after a two-stage synchroniser. While it is seen, the write pointer is held at DEPTH/2 and the read pointer at 0. After release, the first word captured by the write side is delivered after the half-depth of older entries, followed by the rest in order, with no error at equal rates.
- R7: `rst_n` low on a rising `rclk` edge sets `dout` to 0. It does not change either pointer or `fifo_err`, so delivery resumes from where the read side had advanced to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Parallel input word clock |
| wdata | input | 16 | Transmit word, captured on rising `wclk` |
| rclk | input | 1 | Transmit word clock (bit clock / 16) |
| rst_n | input | 1 | Device-wide active-low synchronous reset (clears `dout` only) |
| fifo_rst_n | input | 1 | Active-low FIFO reset; re-centres pointers and clears the error flag |
| dout | output | 16 | Word handed to the shifter, updated on rising `rclk` |
| fifo_err | output | 1 | Sticky overflow/underflow flag |

## Verification
A corrupted pointer or a broken synchroniser shows up at `dout` within a few `rclk` cycles. The symptoms are a repeated word, a skipped word or a step backwards in the written sequence, and often a spurious `fifo_err` as well. A bad re-centre changes how many stale entries come before the first new word, or loses that word. A flag that does not hold, or that clears on the wrong reset, is visible on `fifo_err` from the next sample. A global reset that wrongly reached the pointers shows up as old data reappearing right after `rst_n` rises.

// File: rtl/txpc_pkg.sv
// Package: shared defaults for the transmit phase-compensation FIFO.
// Assumes: consumers derive pointer widths from DEPTH themselves.
package txpc_pkg;
    parameter int TXPC_DW    = 16;  // transmit word width
    parameter int TXPC_DEPTH = 8;   // storage depth, power of two
    parameter int TXPC_SYNC  = 2;   // synchroniser stages
endpackage

// File: rtl/txpc_sync.sv
// Module: multi-stage synchroniser for a vector, with synchronous reset.
// Assumes: the input changes at most one bit at a time (Gray code) or is a
// level signal; STAGES >= 2.
module txpc_sync #(
    parameter int W = 1,
    parameter int STAGES = txpc_pkg::TXPC_SYNC,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: one synchroniser stage, first stage samples the async input.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= RST_VAL;
                end else begin
                    if (s == 0) stg[s] <= d;
                    else        stg[s] <= stg[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/txpc_mem.sv
// Module: word storage written on the write clock, read asynchronously.
// Assumes: the read address is stable for the read clock edge that uses it,
// which pointer separation guarantees.
module txpc_mem #(
    parameter int DW = txpc_pkg::TXPC_DW,
    parameter int DEPTH = txpc_pkg::TXPC_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Purpose: capture one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/txpc_wr.sv
// Module: write-side pointer, full detection and overflow flag.
// Assumes: frst_n is already synchronised into this clock; rgray_s is the
// read pointer in Gray code, synchronised into this clock.
module txpc_wr #(
    parameter int DEPTH = txpc_pkg::TXPC_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          frst_n,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          err
);
    localparam logic [PW-1:0] HALF      = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HALF_GRAY = HALF ^ (HALF >> 1);
    localparam logic [PW-1:0] FULLCNT   = PW'(DEPTH);

    logic [PW-1:0] wptr, wptr_nxt, rbin_s, fill;
    logic          full;

    // Purpose: convert the synchronised Gray read pointer to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign fill     = wptr - rbin_s;
    assign full     = (fill == FULLCNT);
    assign we       = frst_n && !full;
    assign waddr    = wptr[AW-1:0];
    assign wptr_nxt = wptr + PW'(1);

    // Purpose: advance the write pointer, or park it half a depth ahead in FIFO reset.
    always_ff @(posedge clk) begin
        if (!frst_n) begin
            wptr  <= HALF;
            wgray <= HALF_GRAY;
        end else if (!full) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // Purpose: sticky overflow flag, cleared only by FIFO reset.
    always_ff @(posedge clk) begin
        if (!frst_n)   err <= 1'b0;
        else if (full) err <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!frst_n)
        full |=> $stable(wptr)); // R3
    AST_WERR_STICKY: assert property (@(posedge clk) disable iff (!frst_n)
        err |=> err); // R5
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!frst_n)
        $onehot0(wgray ^ $past(wgray))); // R1
    AST_WPTR_CENTRE: assert property (@(posedge clk)
        !frst_n |=> (wptr == HALF)); // R6
endmodule

// File: rtl/txpc_rd.sv
// Module: read-side pointer, empty detection, output word and underflow flag.
// Assumes: frst_n is synchronised into this clock; wgray_s is the write
// pointer in Gray code, synchronised into this clock; rst_n is synchronous.
module txpc_rd #(
    parameter int DW = txpc_pkg::TXPC_DW,
    parameter int DEPTH = txpc_pkg::TXPC_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          frst_n,
    input  logic          rst_n,
    input  logic [PW-1:0] wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] dout,
    output logic          err
);
    logic [PW-1:0] rptr, rptr_nxt, wbin_s;
    logic          empty;

    // Purpose: convert the synchronised Gray write pointer to binary.
    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign empty    = (rptr == wbin_s);
    assign raddr    = rptr[AW-1:0];
    assign rptr_nxt = rptr + PW'(1);

    // Purpose: advance the read pointer, or hold it at zero in FIFO reset.
    always_ff @(posedge clk) begin
        if (!frst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (!empty) begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // Purpose: output word; cleared by global reset, held when nothing to read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dout <= '0;
        else if (frst_n && !empty)  dout <= rdata;
    end

    // Purpose: sticky underflow flag, cleared only by FIFO reset.
    always_ff @(posedge clk) begin
        if (!frst_n)    err <= 1'b0;
        else if (empty) err <= 1'b1;
    end

    AST_UNDERFLOW_REPEAT: assert property (@(posedge clk) disable iff (!frst_n)
        (empty && rst_n) |=> $stable(dout)); // R4
    AST_RPTR_HOLD: assert property (@(posedge clk) disable iff (!frst_n)
        empty |=> $stable(rptr)); // R4
    AST_RERR_STICKY: assert property (@(posedge clk) disable iff (!frst_n)
        err |=> err); // R5
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!frst_n)
        $onehot0(rgray ^ $past(rgray))); // R2
    AST_DOUT_CLEAR: assert property (@(posedge clk) disable iff (!frst_n)
        !rst_n |=> (dout == '0)); // R7
endmodule

// File: rtl/tx_phase_fifo.sv
// Module: transmit phase-compensation FIFO, top level.
// Assumes: wclk and rclk have equal nominal rate with arbitrary phase;
// fifo_rst_n and rst_n are active low; only fifo_rst_n touches the pointers
// and the error flag.
module tx_phase_fifo #(
    parameter int DW = txpc_pkg::TXPC_DW,
    parameter int DEPTH = txpc_pkg::TXPC_DEPTH,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fifo_rst_n,
    output logic [DW-1:0] dout,
    output logic          fifo_err
);
    localparam logic [PW-1:0] HALF      = PW'(DEPTH / 2);
    localparam logic [PW-1:0] HALF_GRAY = HALF ^ (HALF >> 1);

    logic          frst_w, frst_r, we, werr, rerr;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [DW-1:0] rdata;

    txpc_sync #(.W(1), .RST_VAL(1'b0)) u_frst_w (
        .clk(wclk), .rst_n(fifo_rst_n), .d(1'b1), .q(frst_w));
    txpc_sync #(.W(1), .RST_VAL(1'b0)) u_frst_r (
        .clk(rclk), .rst_n(fifo_rst_n), .d(1'b1), .q(frst_r));
    txpc_sync #(.W(PW), .RST_VAL(HALF_GRAY)) u_wptr_s (
        .clk(rclk), .rst_n(frst_r), .d(wgray), .q(wgray_s));
    txpc_sync #(.W(PW), .RST_VAL('0)) u_rptr_s (
        .clk(wclk), .rst_n(frst_w), .d(rgray), .q(rgray_s));

    txpc_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata));

    txpc_wr #(.DEPTH(DEPTH)) u_wr (
        .clk(wclk), .frst_n(frst_w), .rgray_s(rgray_s), .we(we),
        .waddr(waddr), .wgray(wgray), .err(werr));

    txpc_rd #(.DW(DW), .DEPTH(DEPTH)) u_rd (
        .clk(rclk), .frst_n(frst_r), .rst_n(rst_n), .wgray_s(wgray_s),
        .rdata(rdata), .raddr(raddr), .rgray(rgray), .dout(dout), .err(rerr));

    assign fifo_err = werr | rerr;
endmodule

// File: tb/sim_tx_phase_fifo.sv
module sim_tx_phase_fifo;
    logic wclk_r = 1'b0, rclk_r = 1'b0, wrun = 1'b1, rrun = 1'b1;
    logic wclk, rclk;
    logic rst_n = 1'b0, fifo_rst_n = 1'b0;
    logic [15:0] dout;
    logic fifo_err;
    logic [3:0]  tag = 4'd0, prev_tag = 4'd0;
    logic [11:0] cnt = 12'd0;
    logic [15:0] wdata = 16'd0, last_wr = 16'd0;
    logic [15:0] obs [0:63];
    int total = 0, fails = 0;
    bit done = 0;

    initial forever #2.5 wclk_r = ~wclk_r;
    initial begin #2; forever #2.5 rclk_r = ~rclk_r; end
    assign wclk = wclk_r & wrun;
    assign rclk = rclk_r & rrun;

    tx_phase_fifo u0 (.wclk(wclk), .wdata(wdata), .rclk(rclk), .rst_n(rst_n),
                      .fifo_rst_n(fifo_rst_n), .dout(dout), .fifo_err(fifo_err));

    // Word source: {tag, counter}; counter restarts when the tag changes.
    always @(negedge wclk_r) if (wrun) begin
        if (tag != prev_tag) begin
            prev_tag <= tag; wdata <= {tag, 12'd0}; cnt <= 12'd1;
        end else begin
            wdata <= {tag, cnt}; cnt <= cnt + 12'd1;
        end
    end
    always @(posedge wclk) last_wr <= wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic collect(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk_r);
            obs[i] = dout;
        end
    endtask

    // Check obs[a..b] step by exactly one.
    task automatic check_run(input int a, input int b, input string req);
        bit ok = 1; logic [15:0] act = 0, exp = 0;
        for (int i = a + 1; i <= b; i++) begin
            if (ok && obs[i] !== obs[i-1] + 16'd1) begin
                ok = 0; act = obs[i]; exp = obs[i-1] + 16'd1;
            end
        end
        check(ok, req, act, exp);
    endtask

    task automatic t_reset;
        repeat (6) @(negedge rclk_r);
        check(fifo_err === 1'b0, "R6 error low in FIFO reset", fifo_err, 0);
        check(dout === 16'd0, "R7 dout cleared by global reset", dout, 0);
        rst_n = 1'b1;
    endtask

    // Re-centre and check the first delivered words (R6, R1, R2, R5).
    task automatic t_centre(input logic [3:0] t, input string req);
        int first = -1;
        @(negedge wclk_r) fifo_rst_n = 1'b0;
        repeat (4) @(posedge wclk_r);
        #1; tag = t; fifo_rst_n = 1'b1;
        collect(40);
        for (int i = 0; i < 40; i++)
            if (first < 0 && obs[i][15:12] === t) first = i;
        check(first >= 0 && first <= 16, "R6 new word delivered after re-centre", first, 8);
        if (first < 0) first = 0;
        check(obs[first][11:0] <= 12'd4, "R6 first captured word not lost", obs[first], {t, 12'd1});
        check_run(first, first + 20, "R1 R2 in-order gap-free delivery");
        check(fifo_err === 1'b0, req, fifo_err, 0);
    endtask

    task automatic t_overflow;
        bit gap = 0, mono = 1;
        @(negedge rclk_r) rrun = 1'b0;
        repeat (16) @(posedge wclk_r);
        #1;
        check(fifo_err === 1'b1, "R3 error on overflow", fifo_err, 1);
        @(negedge rclk_r) rrun = 1'b1;
        collect(24);
        for (int i = 1; i < 24; i++) begin
            if (!(obs[i] > obs[i-1])) mono = 0;
            if (obs[i] > obs[i-1] + 16'd1) gap = 1;
        end
        check(mono, "R3 stored words kept in order", mono, 1);
        check(gap, "R3 incoming word dropped when full", gap, 1);
    endtask

    task automatic t_underflow;
        @(negedge wclk_r) wrun = 1'b0;
        collect(16);
        check(obs[12] === last_wr && obs[15] === last_wr, "R4 last word repeated", obs[15], last_wr);
        check(fifo_err === 1'b1, "R4 error on underflow", fifo_err, 1);
        @(negedge wclk_r) wrun = 1'b1;
        repeat (10) @(negedge rclk_r);
        check(fifo_err === 1'b1, "R5 error sticky after traffic resumes", fifo_err, 1);
    endtask

    task automatic t_grst_err;
        @(negedge rclk_r) rst_n = 1'b0;
        repeat (2) @(negedge rclk_r);
        check(dout === 16'd0, "R7 dout zero in global reset", dout, 0);
        check(fifo_err === 1'b1, "R7 global reset keeps error", fifo_err, 1);
        @(negedge rclk_r) rst_n = 1'b1;
    endtask

    task automatic t_grst_stream;
        logic [15:0] last;
        collect(6);
        last = obs[5];
        rst_n = 1'b0;
        repeat (3) @(negedge rclk_r);
        rst_n = 1'b1;
        collect(12);
        check(obs[0] > last, "R7 pointers not moved back by global reset", obs[0], last);
        check_run(0, 11, "R7 delivery continues after global reset");
        check(fifo_err === 1'b0, "R7 no error from global reset", fifo_err, 0);
    endtask

    initial begin
        #50000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_centre(4'd1, "R6 no error after first re-centre");
        t_overflow();
        t_centre(4'd2, "R5 FIFO reset clears overflow error");
        t_underflow();
        t_grst_err();
        t_centre(4'd3, "R5 FIFO reset clears underflow error");
        t_grst_stream();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule